// File: doc/BRIEF.md
# Bus Access History Recorder

This block sits beside a simple single-clock register bus and listens without driving it. For every bus access that passes an address filter, it stores a 32-bit summary that packs the access direction, a few address bits and a subset of the data bits. The summaries go into a circular store of 512 entries. Software reads them back, oldest first, by issuing bus reads to one reserved address.

The store never refuses a record. While it holds 512 entries, it discards its oldest entry on every cycle. A new record arriving in the same cycle therefore takes the freed slot, and the log always keeps the most recent history.

The readout returns its data on a plain two-signal output: a one-cycle `trace_valid` pulse with `trace_data`. The bus cannot be stalled, so this output has no ready input and no back-pressure. A consumer must take the word in the cycle it is flagged. A write access is recorded in the cycle of its strobe. A read access is recorded one cycle later, when the bus read data has come back.

Top module: `bus_trace_buffer`

## Requirements
- R1: A write strobe to an accepted address stores an entry in the same cycle. The entry has bit 31 set to 1 and takes its data fields from `bus_wdata`.
- R2: A read strobe to an accepted address stores an entry one cycle after the strobe. The entry has bit 31 set to 0. Its address fields come from the address present during the strobe, and its data fields come from `bus_rdata` in the following cycle.
- R3: No access is recorded when address bits 11:0 equal 0x702 or 0x273.
- R4: No access is recorded when address bits 11:8 equal 0xE. This includes every readout access.
- R5: An entry is packed as follows, from bit 31 down:
  - bit 31: the write flag
  - bits 30:28: address bits 10:8
  - bits 27:24: address bits 3:0
  - bits 23:20: data bits 31:28
  - bits 19:0: data bits 19:0
- R6: A bus read with `bus_addr` equal to 0x0E0E removes the oldest stored entry. That entry appears on `trace_data` one cycle after the strobe, with `trace_valid` high for exactly that cycle. Entries come out in the order they were stored.
- R7: A readout while the store is empty returns zero with `trace_valid` high, and removes nothing.
- R8: Whenever the store holds 512 entries, it discards its oldest entry in that cycle.
  - If a record arrives in the same cycle, the level stays at 512 and the new record is kept.
  - If no record arrives, the level drops to 511.
  - A readout in such a cycle returns the discarded entry and removes only that one.
- R9: When an accepted write strobe falls in the cycle in which a pending read would be recorded, only the write is stored and the read record is lost.
- R10: A synchronous active-high `rst` empties the store and cancels any pending read record. While `rst` is high, and after it is released, `trace_valid` and `trace_data` are 0.
- R11: In every cycle that is not the one following a readout strobe, `trace_valid` is 0 and `trace_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address, valid with either strobe |
| bus_wdata | input | 32 | Bus write data, valid with the write strobe |
| bus_rdata | input | 32 | Bus read data, returned one cycle after a read strobe |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| trace_valid | output | 1 | High for one cycle after a readout strobe |
| trace_data | output | 32 | Oldest stored entry, or zero; zero when `trace_valid` is low |

## Verification
Each result has a fixed latency:
- A write becomes a stored entry at the edge that samples its strobe.
- A read becomes a stored entry at the next edge, using the read data present at that edge.
- A readout word appears on the outputs just after the edge that samples the readout strobe.

The bench drives inputs on the falling edge and updates a queue model at that moment, for the rising edge that follows. At the next falling edge, before it drives anything new, it compares `trace_valid` and `trace_data` with the values the model predicted. Every comparison therefore lands exactly one edge after its stimulus. This includes the 512-entry discard cycles, where a push and a discard share one edge.

// File: rtl/trc_pkg.sv
`timescale 1ns/100ps
package trc_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int ENTRY_W = 32;

  typedef struct packed {
    logic        is_wr;
    logic [2:0]  addr_hi;
    logic [3:0]  addr_lo;
    logic [3:0]  data_top;
    logic [19:0] data_low;
  } trc_entry_t;

  function automatic trc_entry_t pack_entry(input logic wr,
                                            input logic [ADDR_W-1:0] a,
                                            input logic [DATA_W-1:0] d);
    trc_entry_t e;
    e.is_wr    = wr;
    e.addr_hi  = a[10:8];
    e.addr_lo  = a[3:0];
    e.data_top = d[31:28];
    e.data_low = d[19:0];
    return e;
  endfunction
endpackage

// File: rtl/trc_capture.sv
`timescale 1ns/100ps
module trc_capture
  import trc_pkg::*;
#(
  parameter int                   NUM_SKIP     = 2,
  parameter logic [NUM_SKIP*12-1:0] SKIP_LIST  = {12'h273, 12'h702},
  parameter logic [3:0]           SKIP_PAGE    = 4'hE,
  parameter logic [ADDR_W-1:0]    READOUT_ADDR = 16'h0E0E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              push_o,
  output trc_entry_t        entry_o,
  output logic              rdo_o
);
  // per-address exclusion comparators
  logic [NUM_SKIP-1:0] skip_hit;
  for (genvar i = 0; i < NUM_SKIP; i++) begin : g_skip
    assign skip_hit[i] = (bus_addr[11:0] == SKIP_LIST[i*12 +: 12]);
  end

  logic addr_ok;
  assign addr_ok = ~|skip_hit && (bus_addr[11:8] != SKIP_PAGE);

  logic wr_ok, rd_ok;
  assign wr_ok = bus_wr && addr_ok;
  assign rd_ok = bus_rd && addr_ok;

  // read record waits one cycle for returned data
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend   <= rd_ok;
      rd_addr_q <= bus_addr;
    end
  end

  always_comb begin
    push_o  = 1'b0;
    entry_o = '0;
    if (wr_ok) begin
      push_o  = 1'b1;
      entry_o = pack_entry(1'b1, bus_addr, bus_wdata);
    end else if (rd_pend) begin
      push_o  = 1'b1;
      entry_o = pack_entry(1'b0, rd_addr_q, bus_rdata);
    end
  end

  assign rdo_o = bus_rd && (bus_addr == READOUT_ADDR);

  // R2
  rd_to_push_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && !wr_ok) |=> (bus_wr || (push_o && !entry_o.is_wr)));

  // R3
  skip_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr[11:0] == 12'h702 || bus_addr[11:0] == 12'h273))
      |-> !(push_o && entry_o.is_wr));

  // R9
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && wr_ok) |-> (push_o && entry_o.is_wr));
endmodule

// File: rtl/trc_store.sv
`timescale 1ns/100ps
module trc_store #(
  parameter int DEPTH = 512,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         rdo_i,
  output logic [W-1:0] dout_o,
  output logic         dout_valid_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] level;

  logic full, empty, pop;
  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign pop   = (rdo_i || full) && !empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_i) wptr <= bump(wptr);
      if (pop)    rptr <= bump(rptr);
      case ({push_i, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o       <= '0;
      dout_valid_o <= 1'b0;
    end else begin
      dout_valid_o <= rdo_i;
      dout_o       <= (rdo_i && !empty) ? mem[rptr] : '0;
    end
  end

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push_i) |=> (level == CW'(DEPTH)));

  // R6
  readout_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rdo_i |=> dout_valid_o);

  // R7
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdo_i && empty) |=> (dout_o == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rdo_i |=> (!dout_valid_o && dout_o == '0));
endmodule

// File: rtl/bus_trace_buffer.sv
`timescale 1ns/100ps
module bus_trace_buffer
  import trc_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              trace_valid,
  output logic [DATA_W-1:0] trace_data
);
  logic       push;
  trc_entry_t entry;
  logic       rdo;

  trc_capture #(
    .NUM_SKIP    (2),
    .SKIP_LIST   ({12'h273, 12'h702}),
    .SKIP_PAGE   (4'hE),
    .READOUT_ADDR(16'h0E0E)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .push_o   (push),
    .entry_o  (entry),
    .rdo_o    (rdo)
  );

  trc_store #(
    .DEPTH(DEPTH),
    .W    (ENTRY_W)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push),
    .din_i       (entry),
    .rdo_i       (rdo),
    .dout_o      (trace_data),
    .dout_valid_o(trace_valid)
  );

  // R4
  page_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[11:8] == 4'hE) |-> !(push && entry.is_wr));

  // R1
  wr_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[11:8] != 4'hE && bus_addr[11:0] != 12'h702 &&
     bus_addr[11:0] != 12'h273) |-> (push && entry.is_wr));
endmodule

// File: tb/test_bus_trace_buffer.sv
`timescale 1ns/100ps
module test_bus_trace_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        trace_valid;
  logic [31:0] trace_data;

  always #2.5 clk = ~clk;

  bus_trace_buffer i_bus_trace_buffer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .trace_valid(trace_valid), .trace_data(trace_data)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [31:0] mq[$];
  bit          pend = 1'b0;
  logic [15:0] pend_a = '0;
  bit          exp_v = 1'b0;
  logic [31:0] exp_d = '0;
  string       exp_tag = "R10";
  string       cur_tag = "R10";

  function automatic bit pass_f(input logic [15:0] a);
    return a[11:0] != 12'h702 && a[11:0] != 12'h273 && a[11:8] != 4'hE;
  endfunction

  function automatic logic [31:0] pk(input bit w, input logic [15:0] a,
                                     input logic [31:0] d);
    return {w, a[10:8], a[3:0], d[31:28], d[19:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mq.delete();
    pend   = 1'b0;
    exp_v  = 1'b0;
    exp_d  = '0;
  endtask

  // one bus cycle: check previous edge, drive, predict next edge
  task automatic cyc(input logic [15:0] a, input logic [31:0] wd,
                     input bit rd, input bit wr, input logic [31:0] rdin);
    bit          hp;
    logic [31:0] pv;
    @(negedge clk);
    check(exp_v ? exp_tag : "R11", {31'd0, trace_valid}, {31'd0, exp_v});
    check(exp_v ? exp_tag : "R11", trace_data, exp_d);
    bus_addr = a; bus_wdata = wd; bus_rd = rd; bus_wr = wr; bus_rdata = rdin;
    exp_v   = rd && (a == 16'h0E0E);
    exp_tag = (mq.size() == 0) ? "R7" : cur_tag;
    exp_d   = (exp_v && mq.size() != 0) ? mq[0] : 32'd0;
    hp = 1'b0; pv = '0;
    if (wr && pass_f(a)) begin hp = 1'b1; pv = pk(1'b1, a, wd); end
    else if (pend)       begin hp = 1'b1; pv = pk(1'b0, pend_a, rdin); end
    if ((exp_v || mq.size() == 512) && mq.size() != 0) void'(mq.pop_front());
    if (hp) mq.push_back(pv);
    pend   = rd && pass_f(a);
    pend_a = a;
  endtask

  task automatic idle(); cyc(16'h0, 32'h0, 1'b0, 1'b0, $urandom); endtask
  task automatic rdo();  cyc(16'h0E0E, 32'h0, 1'b1, 1'b0, $urandom); endtask
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cyc(a, d, 1'b0, 1'b1, $urandom);
  endtask
  task automatic rd(input logic [15:0] a); cyc(a, 32'h0, 1'b1, 1'b0, $urandom); endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", {31'd0, trace_valid}, 32'd0);
    check("R10", trace_data, 32'd0);
    model_reset();
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    cur_tag = "R10";
    rdo(); idle();

    cur_tag = "R1";
    wr(16'h0123, 32'hA5A5_1234); rdo(); idle();

    cur_tag = "R2";
    cyc(16'h0456, 32'h0, 1'b1, 1'b0, 32'h1111_1111);
    cyc(16'h0000, 32'h0, 1'b0, 1'b0, 32'hDEAD_BEEF);
    rdo(); idle();

    cur_tag = "R3";
    wr(16'h1702, 32'h1); wr(16'h0273, 32'h2); rd(16'h8702); idle();
    wr(16'h0001, 32'h3); rdo(); rdo(); idle();

    cur_tag = "R4";
    wr(16'h0E11, 32'h4); rd(16'h3E00); idle(); rdo(); rdo(); rdo(); idle();

    cur_tag = "R5";
    wr(16'hF70F, 32'hF00F_FFFF); wr(16'h08F0, 32'h0FF0_0000);
    rd(16'h0505); cyc(16'h0, 32'h0, 1'b0, 1'b0, 32'h9ABC_DEF0);
    rdo(); rdo(); rdo(); idle();

    cur_tag = "R9";
    rd(16'h0010); wr(16'h0020, 32'h5555_AAAA); rdo(); rdo(); idle();

    cur_tag = "R8";
    for (int i = 0; i < 520; i++) wr(16'(i), 32'(i * 7 + 1));
    rdo(); idle(); idle();
    wr(16'h0031, 32'h7777_0000);
    for (int i = 0; i < 515; i++) rdo();
    idle();

    cur_tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int          k;
      logic [15:0] a;
      k = int'($urandom_range(0, 9));
      case (k)
        0: a = 16'h0702;
        1: a = 16'h4273;
        2: a = {4'($urandom), 4'hE, 8'($urandom)};
        3, 4: a = 16'h0E0E;
        default: a = 16'($urandom);
      endcase
      cyc(a, $urandom, ($urandom_range(0, 2) == 0) || k >= 3 && k <= 4,
          ($urandom_range(0, 1) == 0) && k != 3 && k != 4, $urandom);
    end
    idle();

    cur_tag = "R10";
    wr(16'h0044, 32'h1);
    do_reset();
    rdo(); idle(); idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule